// File: doc/BRIEF.md
# Selectable PRBS and Fixed-Pattern Serial Generator

This block is a serial test-sequence source for exercising links and line equipment. Each enabled clock emits one bit on `tx_out`. A 4-bit kind code selects the source. The codes with the top bit clear pick one of eight maximal-length pseudo-random sequences. All eight sequences share a single 31-stage shift register, and each sequence feeds back the XOR of its own two stages. The codes with the top bit set pick one of eight fixed 8-bit words, which are sent repeatedly from their leftmost bit.

The kind code and a polarity flag are captured together, and only on a clock where `cfg_load` is high. The same clock restarts the chosen source from its starting point. An error strobe, `bit_flip`, corrupts exactly the bit sent on its clock and leaves the sequence underneath untouched. Error-rate pacing lives outside the block and arrives only through that strobe. One of the 20-stage sequences adds a rule that limits runs of zeros: once the line has carried 14 zeros in a row, the next bit sent is a one.

Top module: `prbs_pattern_gen`

## Requirements
- R1: While `rst_n` is low and after it is released, `tx_out` is 0. Without any `cfg_load`, the block runs kind 0000 with polarity normal from the all-ones register state.
- R2: On a clock where `clk_en` is low and `cfg_load` is low, `tx_out` and all sequence state hold their values.
- R3: Kind 0000 is a 511-bit sequence. On each step the register shifts toward higher stages, and stage 1 takes the XOR of stages 5 and 9. That feedback bit is the bit sent.
- R4: Kinds 0001 to 0111 use the same scheme with the stage pairs (9,11), (14,15), (17,20), (3,20), (18,23), (27,29) and (28,31), in that order.
- R5: Only under kind 0100 (stages 3 and 20), a bit is sent as one when the previous 14 line bits were all zero. The line bit here is the value after the error flip and before polarity inversion. Even then the register takes the unforced feedback bit.
- R6: Kinds 1000 to 1111 repeat, in order, the words 00000000, 11111111, 01010101, 00110011, 01111111, 10000000, 01110111 and 10001000, each sent from its leftmost bit.
- R7: With polarity inverted (`cfg_invert`=1 at load), every pseudo-random bit is complemented. Fixed patterns are never complemented.
- R8: Changes on `cfg_kind` and `cfg_invert` while `cfg_load` is low have no effect on the output.
- R9: A clock with `cfg_load` high holds `tx_out` and resets the register to all ones and the pattern position to its first bit. This happens whatever `clk_en` is. The first enabled clock after it sends the first bit of the new selection.
- R10: With `bit_flip` high on an enabled clock, that clock's bit is complemented. Later bits follow the uncorrupted sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Advances the source and updates the output when high |
| cfg_load | input | 1 | Captures kind and polarity and restarts the source |
| cfg_kind | input | 4 | Source selection code |
| cfg_invert | input | 1 | Polarity flag for pseudo-random kinds |
| bit_flip | input | 1 | Complements the bit sent on this enabled clock |
| tx_out | output | 1 | Registered serial output |

## Verification
The hardest condition to reach from the ports is the zero-run rule of kind 0100. A natural run of 14 zeros appears only rarely in a 2^20-1 sequence. The stimulus therefore predicts each coming bit from the bench's own model of the register and drives `bit_flip` whenever that bit would be one. This puts 14 zeros on the line within a few cycles. The bench then lets the next bit go unflipped and expects a forced one. The same manoeuvre under kind 0011 shows that the rule is confined to its own variant.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;

  typedef struct packed {
    logic [4:0] stage_hi;
    logic [4:0] stage_lo;
    logic       run_limit;
  } fb_pair_t;

  // Feedback stage pair per pseudo-random kind; the order is the kind encoding.
  function automatic fb_pair_t fb_pair_for(input logic [2:0] sel);
    fb_pair_t p;
    p.run_limit = 1'b0;
    unique case (sel)
      3'd0: begin p.stage_hi = 5'd9;  p.stage_lo = 5'd5;  end
      3'd1: begin p.stage_hi = 5'd11; p.stage_lo = 5'd9;  end
      3'd2: begin p.stage_hi = 5'd15; p.stage_lo = 5'd14; end
      3'd3: begin p.stage_hi = 5'd20; p.stage_lo = 5'd17; end
      3'd4: begin p.stage_hi = 5'd20; p.stage_lo = 5'd3;  p.run_limit = 1'b1; end
      3'd5: begin p.stage_hi = 5'd23; p.stage_lo = 5'd18; end
      3'd6: begin p.stage_hi = 5'd29; p.stage_lo = 5'd27; end
      default: begin p.stage_hi = 5'd31; p.stage_lo = 5'd28; end
    endcase
    return p;
  endfunction

  // Fixed words, leftmost bit sent first.
  function automatic logic [7:0] word_for(input logic [2:0] sel);
    unique case (sel)
      3'd0: return 8'b0000_0000;
      3'd1: return 8'b1111_1111;
      3'd2: return 8'b0101_0101;
      3'd3: return 8'b0011_0011;
      3'd4: return 8'b0111_1111;
      3'd5: return 8'b1000_0000;
      3'd6: return 8'b0111_0111;
      default: return 8'b1000_1000;
    endcase
  endfunction

  // Saturating zero-run count update.
  function automatic logic [3:0] run_next(input logic [3:0] cur, input logic line_bit,
                                          input logic [3:0] limit);
    if (line_bit) return 4'd0;
    if (cur >= limit) return limit;
    return cur + 4'd1;
  endfunction

endpackage

// File: rtl/prbs_shift_core.sv
module prbs_shift_core
  import prbs_gen_pkg::*;
#(
  parameter int REG_W     = 31,
  parameter int RUN_LIMIT = 14,
  localparam int RUN_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic             prbs_mode,
  input  logic [2:0]       sel,
  input  logic             line_bit,
  output logic             fb_bit,
  output logic             force_one,
  output logic [REG_W-1:0] state_q,
  output logic [RUN_W-1:0] run_q
);

  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LIMIT);

  fb_pair_t pair;
  logic     bit_hi;
  logic     bit_lo;

  always_comb begin
    pair   = fb_pair_for(sel);
    bit_hi = state_q[pair.stage_hi - 5'd1];
    bit_lo = state_q[pair.stage_lo - 5'd1];
  end

  assign fb_bit    = bit_hi ^ bit_lo;
  assign force_one = prbs_mode & pair.run_limit & (run_q == RUN_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '1;
      run_q   <= '0;
    end else if (restart) begin
      state_q <= '1;
      run_q   <= '0;
    end else if (advance) begin
      state_q <= {state_q[REG_W-2:0], fb_bit};
      run_q   <= run_next(run_q, line_bit, RUN_MAX);
    end
  end

endmodule

// File: rtl/prbs_word_rotator.sv
module prbs_word_rotator
  import prbs_gen_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int POS_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic [2:0]       sel,
  output logic             word_bit,
  output logic [POS_W-1:0] pos_q
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W - 1);

  logic [WORD_W-1:0] word;

  assign word     = WORD_W'(word_for(sel));
  assign word_bit = word[LAST_POS - pos_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (restart) begin
      pos_q <= '0;
    end else if (advance) begin
      pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + POS_W'(1);
    end
  end

endmodule

// File: rtl/prbs_line_stage.sv
module prbs_line_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic pattern_mode,
  input  logic invert,
  input  logic prbs_bit,
  input  logic word_bit,
  input  logic flip,
  output logic line_bit,
  output logic tx_q
);

  logic src_bit;
  logic tx_d;

  assign src_bit  = pattern_mode ? word_bit : prbs_bit;
  assign line_bit = src_bit ^ flip;
  assign tx_d     = line_bit ^ (invert & ~pattern_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_q <= 1'b0;
    else if (advance) tx_q <= tx_d;
  end

endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen #(
  parameter int REG_W     = 31,
  parameter int RUN_LIMIT = 14,
  parameter int WORD_W    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_en,
  input  logic       cfg_load,
  input  logic [3:0] cfg_kind,
  input  logic       cfg_invert,
  input  logic       bit_flip,
  output logic       tx_out
);

  localparam int RUN_W = 4;
  localparam int POS_W = $clog2(WORD_W);

  logic [3:0]       kind_q;
  logic             inv_q;
  logic             step;
  logic             pattern_mode;
  logic             fb_bit;
  logic             force_one;
  logic             prbs_bit;
  logic             word_bit;
  logic             line_bit;
  logic [REG_W-1:0] lfsr_q;
  logic [RUN_W-1:0] run_q;
  logic [POS_W-1:0] pos_q;

  assign step         = clk_en & ~cfg_load;
  assign pattern_mode = kind_q[3];
  assign prbs_bit     = fb_bit | force_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= 4'd0;
      inv_q  <= 1'b0;
    end else if (cfg_load) begin
      kind_q <= cfg_kind;
      inv_q  <= cfg_invert;
    end
  end

  prbs_shift_core #(.REG_W(REG_W), .RUN_LIMIT(RUN_LIMIT)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (cfg_load),
    .advance   (step),
    .prbs_mode (~pattern_mode),
    .sel       (kind_q[2:0]),
    .line_bit  (line_bit),
    .fb_bit    (fb_bit),
    .force_one (force_one),
    .state_q   (lfsr_q),
    .run_q     (run_q)
  );

  prbs_word_rotator #(.WORD_W(WORD_W)) u_rot (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (cfg_load),
    .advance  (step),
    .sel      (kind_q[2:0]),
    .word_bit (word_bit),
    .pos_q    (pos_q)
  );

  prbs_line_stage u_line (
    .clk          (clk),
    .rst_n        (rst_n),
    .advance      (step),
    .pattern_mode (pattern_mode),
    .invert       (inv_q),
    .prbs_bit     (prbs_bit),
    .word_bit     (word_bit),
    .flip         (bit_flip),
    .line_bit     (line_bit),
    .tx_q         (tx_out)
  );

endmodule

// File: rtl/prbs_pattern_gen_checker.sv
module prbs_pattern_gen_checker #(
  parameter int REG_W     = 31,
  parameter int RUN_LIMIT = 14,
  parameter int RUN_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_en,
  input logic             cfg_load,
  input logic             bit_flip,
  input logic             tx_out,
  input logic             step,
  input logic             inv_q,
  input logic             force_one,
  input logic [REG_W-1:0] lfsr_q,
  input logic [RUN_W-1:0] run_q
);

  a_r2_hold_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !cfg_load) |=> $stable(tx_out));

  a_r2_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !cfg_load) |=> ($stable(lfsr_q) && $stable(run_q)));

  a_r9_load_holds_tx: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> $stable(tx_out));

  a_r9_restart_seed: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (lfsr_q == {REG_W{1'b1}}));

  a_r5_forced_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step && force_one) |=> (tx_out == (~$past(bit_flip) ^ inv_q)));

  a_r5_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(RUN_LIMIT));

  a_r10_state_shifts: assert property (@(posedge clk) disable iff (!rst_n)
    (step && bit_flip) |=> (lfsr_q[REG_W-1:1] == $past(lfsr_q[REG_W-2:0])));

endmodule

bind prbs_pattern_gen prbs_pattern_gen_checker #(.REG_W(REG_W), .RUN_LIMIT(RUN_LIMIT), .RUN_W(RUN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_en    (clk_en),
  .cfg_load  (cfg_load),
  .bit_flip  (bit_flip),
  .tx_out    (tx_out),
  .step      (step),
  .inv_q     (inv_q),
  .force_one (force_one),
  .lfsr_q    (lfsr_q),
  .run_q     (run_q)
);

// File: tb/prbs_pattern_gen_test.sv
module prbs_pattern_gen_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0;
  logic       cfg_load = 1'b0;
  logic [3:0] cfg_kind = 4'd0;
  logic       cfg_invert = 1'b0;
  logic       bit_flip = 1'b0;
  logic       tx_out;

  int checks = 0;
  int failures = 0;

  // Independent reference: taps listed high-first, words as constants.
  int         tap_a [8] = '{9, 11, 15, 20, 20, 23, 29, 31};
  int         tap_b [8] = '{5, 9, 14, 17, 3, 18, 27, 28};
  logic [7:0] words [8] = '{8'h00, 8'hFF, 8'h55, 8'h33, 8'h7F, 8'h80, 8'h77, 8'h88};

  logic [30:0] m_r;
  logic [3:0]  m_kind;
  logic        m_inv;
  int          m_idx;
  int          m_z;
  logic        m_tx;

  prbs_pattern_gen uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cfg_load(cfg_load),
    .cfg_kind(cfg_kind), .cfg_invert(cfg_invert), .bit_flip(bit_flip), .tx_out(tx_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic m_fb();
    int k = int'(m_kind[2:0]);
    return m_r[tap_a[k]-1] ^ m_r[tap_b[k]-1];
  endfunction

  function automatic logic m_pred();
    if (m_kind[3]) return words[m_kind[2:0]][7-m_idx];
    if (m_kind == 4'd4 && m_z >= 14) return 1'b1;
    return m_fb();
  endfunction

  task automatic m_adv(input logic flip);
    logic line;
    logic fb;
    line = m_pred() ^ flip;
    fb = m_fb();
    m_r = {m_r[29:0], fb};
    m_idx = (m_idx + 1) % 8;
    m_z = line ? 0 : ((m_z < 14) ? m_z + 1 : 14);
    m_tx = m_kind[3] ? line : (line ^ m_inv);
  endtask

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic tick(input logic en, input logic flip, input string req);
    clk_en = en; bit_flip = flip; cfg_load = 1'b0;
    @(posedge clk);
    if (en) m_adv(flip);
    @(negedge clk);
    check(tx_out, m_tx, req, "tx bit");
  endtask

  task automatic load(input logic [3:0] kind, input logic inv, input logic en);
    cfg_load = 1'b1; cfg_kind = kind; cfg_invert = inv; clk_en = en; bit_flip = 1'b0;
    @(posedge clk);
    m_kind = kind; m_inv = inv; m_r = '1; m_idx = 0; m_z = 0;
    @(negedge clk);
    cfg_load = 1'b0;
    check(tx_out, m_tx, "R9", "held on load");
  endtask

  task automatic t_reset();
    m_r = '1; m_kind = 4'd0; m_inv = 1'b0; m_idx = 0; m_z = 0; m_tx = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_out, 1'b0, "R1", "in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_out, 1'b0, "R1", "after reset");
    for (int i = 0; i < 40; i++) tick(1'b1, 1'b0, "R1");
  endtask

  task automatic t_prbs9_period();
    logic hist [1022];
    int bad = 0;
    load(4'd0, 1'b0, 1'b1);
    for (int i = 0; i < 1022; i++) begin
      tick(1'b1, 1'b0, "R3");
      hist[i] = tx_out;
    end
    for (int i = 0; i < 511; i++) if (hist[i] !== hist[i+511]) bad++;
    check(bad == 0, 1'b1, "R3", "period 511");
  endtask

  task automatic t_all_kinds();
    for (int k = 1; k < 8; k++) begin
      load(4'(k), 1'b0, 1'b0);
      for (int i = 0; i < 300; i++) tick(1'b1, 1'b0, "R4");
    end
  endtask

  task automatic t_words();
    for (int k = 8; k < 16; k++) begin
      load(4'(k), 1'b1, 1'b1);
      for (int i = 0; i < 24; i++) tick(1'b1, 1'b0, "R6");
    end
  endtask

  task automatic t_invert();
    load(4'd2, 1'b1, 1'b1);
    for (int i = 0; i < 200; i++) tick(1'b1, 1'b0, "R7");
    load(4'd10, 1'b1, 1'b1);
    tick(1'b1, 1'b0, "R7");
    check(tx_out, 1'b0, "R7", "word not inverted");
  endtask

  task automatic t_enable();
    load(4'd1, 1'b0, 1'b1);
    for (int i = 0; i < 150; i++) tick((i % 3) != 0, 1'b0, "R2");
  endtask

  task automatic t_cfg_ignored();
    load(4'd2, 1'b0, 1'b1);
    for (int i = 0; i < 10; i++) tick(1'b1, 1'b0, "R8");
    cfg_kind = 4'b1001; cfg_invert = 1'b1;
    for (int i = 0; i < 60; i++) tick(1'b1, 1'b0, "R8");
  endtask

  task automatic t_restart();
    load(4'd5, 1'b0, 1'b1);
    for (int i = 0; i < 37; i++) tick(1'b1, 1'b0, "R9");
    load(4'd6, 1'b0, 1'b0);
    for (int i = 0; i < 80; i++) tick(1'b1, 1'b0, "R9");
    load(4'd14, 1'b0, 1'b1);
    tick(1'b1, 1'b0, "R9");
    check(tx_out, 1'b0, "R9", "word restarts at first bit");
  endtask

  task automatic t_flip();
    load(4'd1, 1'b0, 1'b1);
    for (int i = 0; i < 120; i++) tick(1'b1, (i % 7) == 3, "R10");
    load(4'd7, 1'b1, 1'b1);
    for (int i = 0; i < 120; i++) tick(1'b1, (i % 5) == 1, "R10");
    load(4'd9, 1'b0, 1'b1);
    tick(1'b1, 1'b1, "R10");
    check(tx_out, 1'b0, "R10", "word bit flipped");
  endtask

  task automatic t_zero_run();
    load(4'd4, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, "R5");
    while (m_z < 14) tick(1'b1, m_pred(), "R5");
    tick(1'b1, 1'b0, "R5");
    check(tx_out, 1'b1, "R5", "forced one after 14 zeros");
    for (int i = 0; i < 40; i++) tick(1'b1, 1'b0, "R5");
    load(4'd3, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, "R5");
    while (m_z < 14) tick(1'b1, m_pred(), "R5");
    for (int i = 0; i < 40; i++) tick(1'b1, 1'b0, "R5");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_prbs9_period();
    t_all_kinds();
    t_words();
    t_invert();
    t_enable();
    t_cfg_ignored();
    t_restart();
    t_flip();
    t_zero_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule